// File: doc/BRIEF.md
# Predicated Pairwise Tree Reduction Engine

This block adds up a vector of unsigned integer elements, under a per-element predicate mask, by walking a binary tree of pairings over a number of passes. Software or a neighbouring unit presents the elements, the mask and a run-time length, then pulses start. The engine then performs one pairing per clock until the tree is folded down to position 0. It ends with a one-cycle done pulse and a sum that stays on the outputs until the next start.

Partial sums never move between lanes. Each position carries a redirection entry that names the physical lane holding its partial sum, and a working predicate bit that records whether that position holds any live data. When a left position is empty and its right partner is live, the left entry is pointed at the partner's lane and no value is copied. The working predicate is merged with OR after each pairing. Both tables therefore follow only from the length, the initial mask and the pass number, so they can be rebuilt rather than saved. The stride starts at 2 and doubles every pass. A pass visits left positions 0, stride, 2·stride and so on below the length, and pairs each with the position half a stride to its right. The run ends once the stride reaches twice the length.

Top module: `tree_reduce`

## Requirements
- R1: A start pulse seen while idle captures the length, elements and mask. busy_o is high from the next cycle through the done cycle, and low again the cycle after that.
- R2: When done_o is high, sum_o equals the unsigned sum of every element k (bits k*DATA_W up to k*DATA_W+DATA_W-1 of elem_i) with k below the length and mask bit k set. The sum is SUM_W = DATA_W + clog2(LANES) bits wide, so it does not overflow.
- R3: sum_valid_o is high with done_o exactly when at least one element was active. When no element was active, sum_o is 0.
- R4: A length of 0 or 1 gives done_o in the first cycle after the start edge. Length 0 reports sum_valid_o low. Length 1 reports element 0 when mask bit 0 is set.
- R5: A start pulse received while busy_o is high is ignored. The running reduction completes with its original operands, and no extra done pulse follows.
- R6: done_o is high for exactly one cycle. After it, sum_o and sum_valid_o hold their values until the next start is accepted.
- R7: Mask bits and element values at lanes at or above the length have no effect on the result.
- R8: A length value above LANES is treated as LANES.
- R9: One pairing is made per clock. For length L ≥ 2, done_o rises 1 + P cycles after the start edge, where P is the sum over strides s = 2, 4, … with s < 2L of ceil(L/s).
- R10: An inactive left position with an active right partner takes over the partner's lane by redirection. Sparse masks, including a single active element in the highest lane, still give the correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| len_i | input | LEN_W = clog2(LANES+1) | Vector length for this run |
| elem_i | input | LANES*DATA_W | Packed element values, lane k at bits k*DATA_W upward |
| mask_i | input | LANES | Per-lane predicate, bit k for lane k |
| busy_o | output | 1 | High while a run is in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | SUM_W | Reduction result, zero when no element was active |
| sum_valid_o | output | 1 | High when at least one element contributed |

## Verification
The bench goes after masks where the left operand of a pairing is empty and the right one is live, such as alternating bits and a single top-lane bit. An engine that copied nothing and skipped the redirection would lose those elements and report a short sum or a false invalid. It drives lengths 0, 1, odd values, over-range values and masks with bits set beyond the length. An engine with a wrong bound would add stray lanes, misreport validity or run for the wrong number of cycles, which the latency check against the per-pass pairing count catches. It also fires start in the middle of a run and checks that the result is unchanged and that no second done pulse appears. A design that reloaded its operands would either corrupt the sum or shift the done cycle.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tr_state_e;

endpackage

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched #(
    parameter int LANES = 8,
    parameter int LEN_W = $clog2(LANES + 1),
    parameter int CNT_W = $clog2(LANES) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] left_o,
    output logic [CNT_W-1:0] right_o,
    output logic             in_range_o,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] step;
        logic [CNT_W-1:0] idx;
    } sched_t;

    sched_t s_d, s_q;

    logic [CNT_W-1:0] len_w;
    logic [CNT_W-1:0] nxt_idx;
    logic [CNT_W-1:0] nxt_step;
    logic             pass_end;

    always_comb begin
        len_w      = CNT_W'(len_i);
        right_o    = s_q.idx + (s_q.step >> 1);
        left_o     = s_q.idx;
        in_range_o = right_o < len_w;
        nxt_idx    = s_q.idx + s_q.step;
        nxt_step   = s_q.step << 1;
        pass_end   = nxt_idx >= len_w;
        last_o     = pass_end && (nxt_step >= (len_w << 1));

        s_d = s_q;
        if (load_i) begin
            s_d.step = CNT_W'(2);
            s_d.idx  = '0;
        end else if (adv_i) begin
            if (pass_end) begin
                s_d.idx  = '0;
                s_d.step = nxt_step;
            end else begin
                s_d.idx = nxt_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.step <= CNT_W'(2);
            s_q.idx  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // stride stays a power of two at every pass (one pairing schedule, R9)
    assert_step_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.step) == 1);

    // a left position visited is always inside the vector (R7)
    assert_left_in_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (s_q.idx < len_w));

endmodule

// File: rtl/tree_reduce_pair.sv
module tree_reduce_pair (
    input  logic in_range_i,
    input  logic wp_left_i,
    input  logic wp_right_i,
    output logic right_act_o,
    output logic do_add_o,
    output logic do_redir_o
);

    always_comb begin
        right_act_o = in_range_i && wp_right_i;
        do_add_o    = right_act_o && wp_left_i;
        do_redir_o  = right_act_o && !wp_left_i;
    end

endmodule

// File: rtl/tree_reduce_lanes.sv
module tree_reduce_lanes #(
    parameter int LANES  = 8,
    parameter int DATA_W = 16,
    parameter int SUM_W  = DATA_W + $clog2(LANES),
    parameter int POS_W  = $clog2(LANES),
    parameter int LEN_W  = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [LANES*DATA_W-1:0] elem_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic                    pair_en_i,
    input  logic [POS_W-1:0]        left_i,
    input  logic [POS_W-1:0]        right_i,
    input  logic                    right_act_i,
    input  logic                    do_add_i,
    input  logic                    do_redir_i,
    output logic                    wp_left_o,
    output logic                    wp_right_o,
    output logic [SUM_W-1:0]        res_sum_o,
    output logic                    res_pred_o
);

    typedef struct packed {
        logic [LANES-1:0][SUM_W-1:0] val;
        logic [LANES-1:0][POS_W-1:0] redir;
        logic [LANES-1:0]            wp;
    } lanes_t;

    lanes_t l_d, l_q;

    logic [POS_W-1:0] lane_l;
    logic [POS_W-1:0] lane_r;

    always_comb begin
        lane_l = l_q.redir[left_i];
        lane_r = l_q.redir[right_i];
        l_d    = l_q;
        if (load_i) begin
            for (int k = 0; k < LANES; k++) begin
                l_d.val[k]   = SUM_W'(elem_i[k*DATA_W +: DATA_W]);
                l_d.redir[k] = POS_W'(k);
                l_d.wp[k]    = mask_i[k] && (k < int'(len_i));
            end
        end else if (pair_en_i) begin
            if (do_add_i) begin
                l_d.val[lane_l] = l_q.val[lane_l] + l_q.val[lane_r];
            end
            if (do_redir_i) begin
                l_d.redir[left_i] = lane_r;
            end
            l_d.wp[left_i] = l_q.wp[left_i] | right_act_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q.val <= '0;
            l_q.wp  <= '0;
            for (int k = 0; k < LANES; k++) begin
                l_q.redir[k] <= POS_W'(k);
            end
        end else begin
            l_q <= l_d;
        end
    end

    always_comb begin
        wp_left_o  = l_q.wp[left_i];
        wp_right_o = l_q.wp[right_i];
        res_sum_o  = l_q.val[l_q.redir[0]];
        res_pred_o = l_q.wp[0];
    end

    // a redirected left position becomes live and points at the partner lane (R10)
    assert_redirect_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en_i && do_redir_i && !load_i) |=>
            (l_q.wp[$past(left_i)] && (l_q.redir[$past(left_i)] == $past(lane_r))));

    // an in-place add keeps the left position's lane (R2)
    assert_add_in_place_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en_i && do_add_i && !load_i) |=>
            (l_q.redir[$past(left_i)] == $past(lane_l)));

    // a live position never loses its predicate during a run (R3)
    assert_pred_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en_i && !load_i && wp_left_o) |=> l_q.wp[$past(left_i)]);

endmodule

// File: rtl/tree_reduce.sv
module tree_reduce
    import tree_reduce_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(LANES + 1),
    parameter int SUM_W  = DATA_W + $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [LANES*DATA_W-1:0] elem_i,
    input  logic [LANES-1:0]        mask_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [SUM_W-1:0]        sum_o,
    output logic                    sum_valid_o
);

    localparam int POS_W = $clog2(LANES);
    localparam int CNT_W = $clog2(LANES) + 2;

    typedef struct packed {
        tr_state_e        state;
        logic [LEN_W-1:0] len;
    } top_t;

    top_t t_d, t_q;

    logic             load;
    logic             adv;
    logic [LEN_W-1:0] len_eff;
    logic [CNT_W-1:0] left_c;
    logic [CNT_W-1:0] right_c;
    logic             in_range;
    logic             last;
    logic             wp_left;
    logic             wp_right;
    logic             right_act;
    logic             do_add;
    logic             do_redir;
    logic [SUM_W-1:0] res_sum;
    logic             res_pred;

    always_comb begin
        len_eff = (len_i > LEN_W'(LANES)) ? LEN_W'(LANES) : len_i;
        load    = (t_q.state == ST_IDLE) && start_i;
        adv     = (t_q.state == ST_RUN);
        t_d     = t_q;
        case (t_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    t_d.len   = len_eff;
                    t_d.state = (len_eff <= LEN_W'(1)) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last) begin
                    t_d.state = ST_DONE;
                end
            end
            default: begin
                t_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.state <= ST_IDLE;
            t_q.len   <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    tree_reduce_sched #(
        .LANES (LANES),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .adv_i      (adv),
        .len_i      (t_q.len),
        .left_o     (left_c),
        .right_o    (right_c),
        .in_range_o (in_range),
        .last_o     (last)
    );

    tree_reduce_pair u_pair (
        .in_range_i  (in_range),
        .wp_left_i   (wp_left),
        .wp_right_i  (wp_right),
        .right_act_o (right_act),
        .do_add_o    (do_add),
        .do_redir_o  (do_redir)
    );

    tree_reduce_lanes #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W),
        .POS_W  (POS_W),
        .LEN_W  (LEN_W)
    ) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .len_i       (len_eff),
        .elem_i      (elem_i),
        .mask_i      (mask_i),
        .pair_en_i   (adv),
        .left_i      (left_c[POS_W-1:0]),
        .right_i     (right_c[POS_W-1:0]),
        .right_act_i (right_act),
        .do_add_i    (do_add),
        .do_redir_i  (do_redir),
        .wp_left_o   (wp_left),
        .wp_right_o  (wp_right),
        .res_sum_o   (res_sum),
        .res_pred_o  (res_pred)
    );

    always_comb begin
        busy_o      = (t_q.state != ST_IDLE);
        done_o      = (t_q.state == ST_DONE);
        sum_valid_o = (t_q.state != ST_RUN) && res_pred;
        sum_o       = sum_valid_o ? res_sum : '0;
    end

    // done lasts a single cycle and is followed by idle (R6)
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // an accepted start makes the engine busy on the next cycle (R1)
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // start during a run leaves the captured length alone (R5)
    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(t_q.len));

    // a zero length completes at once with no valid result (R4)
    assert_len_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (len_i == '0)) |=> (done_o && !sum_valid_o));

    // results do not change while idle (R6)
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(sum_valid_o)));

endmodule

// File: tb/tree_reduce_bench.sv
`timescale 1ns/1ps
module tree_reduce_bench;

    localparam int LANES  = 8;
    localparam int DATA_W = 16;
    localparam int LEN_W  = $clog2(LANES + 1);
    localparam int SUM_W  = DATA_W + $clog2(LANES);

    typedef struct {
        logic [SUM_W-1:0] sum;
        logic             valid;
        int               cyc;
        string            tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [LEN_W-1:0]        len_i = '0;
    logic [LANES*DATA_W-1:0] elem_i = '0;
    logic [LANES-1:0]        mask_i = '0;
    logic                    busy_o;
    logic                    done_o;
    logic [SUM_W-1:0]        sum_o;
    logic                    sum_valid_o;

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    exp_t sb_q[$];
    logic prev_done = 1'b0;
    logic [SUM_W-1:0] last_sum = '0;
    logic             last_valid = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tree_reduce #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .SUM_W  (SUM_W)
    ) u_tree_reduce (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .elem_i      (elem_i),
        .mask_i      (mask_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sum_o       (sum_o),
        .sum_valid_o (sum_valid_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pairings(input int len);
        int p = 0;
        for (int s = 2; s < 2 * len; s = s * 2) p += (len + s - 1) / s;
        return p;
    endfunction

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                check(!done_o && !busy_o, "R6 done single cycle then idle", {done_o, busy_o}, 0);
            end
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(sum_o == e.sum, {e.tag, " sum (R2)"}, sum_o, e.sum);
                    check(sum_valid_o == e.valid, {e.tag, " valid (R3)"}, sum_valid_o, e.valid);
                    check(cyc == e.cyc, {e.tag, " done cycle (R9)"}, cyc, e.cyc);
                    last_sum   = e.sum;
                    last_valid = e.valid;
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic run(input int len, input logic [LANES-1:0] mask,
                       input logic [LANES*DATA_W-1:0] elems, input string tag);
        exp_t e;
        int   leff;
        logic [SUM_W-1:0] s;
        leff = (len > LANES) ? LANES : len;
        s = '0;
        e.valid = 1'b0;
        for (int k = 0; k < leff; k++) begin
            if (mask[k]) begin
                s = s + SUM_W'(elems[k*DATA_W +: DATA_W]);
                e.valid = 1'b1;
            end
        end
        e.sum = e.valid ? s : '0;
        e.cyc = cyc + 1 + pairings(leff);
        e.tag = tag;
        sb_q.push_back(e);
        len_i   = LEN_W'(len);
        mask_i  = mask;
        elem_i  = elems;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 || done_o == 1'b1, {tag, " busy after start (R1)"}, busy_o, 1);
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [LANES*DATA_W-1:0] mk(input int base, input int mul);
        logic [LANES*DATA_W-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*DATA_W +: DATA_W] = DATA_W'(base + mul * k);
        return v;
    endfunction

    initial begin : driver
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !sum_valid_o && sum_o == '0, "R1 reset state",
              {busy_o, done_o, sum_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(8, 8'hFF, mk(3, 11), "R2 full vector");
        run(8, 8'hAA, mk(100, 7), "R10 alternating mask");
        run(7, 8'h40, mk(5, 13), "R10 top lane only");
        run(5, 8'b10110, mk(9, 21), "R2 odd length");
        run(3, 8'h00, mk(1, 1), "R3 no active");
        run(0, 8'hFF, mk(4, 4), "R4 length zero");
        run(1, 8'h01, mk(77, 3), "R4 length one live");
        run(1, 8'h00, mk(77, 3), "R4 length one dead");
        run(6, 8'hC1, mk(50, 1000), "R7 mask beyond length");
        run(15, 8'hFF, mk(2, 5), "R8 clamped length");
        run(8, 8'hFF, {LANES{16'hFFFF}}, "R2 max values");
        run(2, 8'h02, mk(40, 2), "R10 redirect length two");

        // hold after done (R6)
        repeat (5) @(negedge clk);
        check(sum_o == last_sum && sum_valid_o == last_valid, "R6 result held", sum_o, last_sum);

        // start during a run is ignored (R5)
        begin
            exp_t e;
            logic [LANES*DATA_W-1:0] v;
            v = mk(10, 10);
            e.sum = SUM_W'(10 + 20 + 30 + 40 + 50 + 60 + 70 + 80);
            e.valid = 1'b1;
            e.cyc = cyc + 1 + pairings(8);
            e.tag = "R5 start while busy";
            sb_q.push_back(e);
            len_i = LEN_W'(8); mask_i = 8'hFF; elem_i = v; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (2) @(negedge clk);
            len_i = LEN_W'(2); mask_i = 8'h03; elem_i = mk(999, 1); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o == 1'b1, "R5 still busy", busy_o, 1);
            while (sb_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(!busy_o && !done_o, "R5 no restart", {busy_o, done_o}, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        wait (cyc > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule